// File: doc/BRIEF.md
# Sample FIFO with Threshold Interrupt

This block sits between a converter's sample output and a host bus. It holds up to `DEPTH` 16-bit sample words, so a slow host that answers interrupts late does not lose samples while space remains. The host pops one word per read strobe and may read the current fill count at any moment. It programs a threshold, and an interrupt line stays high while the fill count is at or above that threshold.

The converter side is a valid/ready stream with one special rule: the converter cannot be stalled. `cv_ready` is high exactly when the store has a free slot. A beat offered with `cv_valid` high while `cv_ready` is low is not held for a later cycle. It is discarded, and a sticky overflow flag records the loss. The host side is plain control: a pop strobe, a registered data word, the level and threshold values, two sticky flags with their clear strobes, and the interrupt line.

The interrupt is level-sensitive. The host acknowledges it by draining the store below the threshold, or by writing a new threshold.

Top module: `smf_top`

## Requirements
- R1: Accepted samples leave in the order they arrived, each as one whole 16-bit word, and up to `DEPTH` samples are held at once.
- R2: `cv_ready` is 1 exactly when the stored count is below `DEPTH`. A beat is accepted at a rising edge where `cv_valid` and `cv_ready` are both 1.
- R3: `level` equals the number of stored samples. It changes at the edge where a sample is accepted or popped, and it is unchanged when both happen at the same edge.
- R4: A `thr_wr` pulse loads `thr_wdata` into the threshold. Values above `DEPTH` are stored as `DEPTH`. `thr_q` shows the stored threshold.
- R5: `irq` is 1 exactly when the threshold is nonzero and `level` is at or above it. It is updated at the same edge as `level` and `thr_q`. A threshold of 0 keeps `irq` at 0.
- R6: A beat offered while `cv_ready` is 0 is dropped, with no change to stored data or to `level`, and sets `flag_ovf`. `clr_ovf` clears the flag. A new overflow at the same edge as the clear leaves the flag set.
- R7: A pop while `level` is 0 leaves `hr_data` unchanged and sets `flag_unf`. `clr_unf` clears it, and a same-edge underflow wins over the clear. A sample accepted at that edge is still stored.
- R8: A pop while `level` is nonzero removes the oldest sample. That sample appears on `hr_data` from the pop edge on.
- R9: After reset, `level`, `thr_q`, `irq`, both flags and `hr_data` are 0, and `cv_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cv_valid | input | 1 | Converter offers a sample |
| cv_data | input | DATA_W | Converter sample word |
| cv_ready | output | 1 | A free slot exists |
| hr_pop | input | 1 | Host read strobe, one word per cycle |
| hr_data | output | DATA_W | Last popped sample |
| level | output | $clog2(DEPTH)+1 | Current number of stored samples |
| thr_wr | input | 1 | Threshold write strobe |
| thr_wdata | input | $clog2(DEPTH)+1 | Threshold value to write |
| thr_q | output | $clog2(DEPTH)+1 | Stored threshold |
| irq | output | 1 | Interrupt request, level-sensitive |
| flag_ovf | output | 1 | Sticky: a sample was dropped |
| flag_unf | output | 1 | Sticky: a pop found the store empty |
| clr_ovf | input | 1 | Clears `flag_ovf` |
| clr_unf | input | 1 | Clears `flag_unf` |

## Verification
For every threshold from 0 through values past `DEPTH`, the bench fills the store one sample at a time to full and then drains it. Checking `irq` and `level` at each step separates an off-by-one compare from a correct one, and shows that the clamp and the zero-threshold case behave as required. The extra write at full and the extra pop at empty separate dropping from overwriting, and holding the data word from corrupting it. Pushes and pops at the same edge at mid fill and at empty, and clears that meet a new event, separate a correct count from one that miscounts concurrent traffic.

// File: rtl/smf_pkg.sv
package smf_pkg;
  // Default word width of one stored sample.
  localparam int unsigned SMF_DATA_W = 16;

  // Index of each sticky flag inside the flag vector.
  localparam int unsigned SMF_FLAG_OVF = 0;
  localparam int unsigned SMF_FLAG_UNF = 1;
  localparam int unsigned SMF_NFLAGS   = 2;

  // Qualified traffic for one cycle.
  typedef struct packed {
    logic push;
    logic pop;
  } smf_ops_t;

  // Width of a count that must be able to hold the value "depth".
  function automatic int unsigned smf_cnt_w(input int unsigned depth);
    return $clog2(depth) + 1;
  endfunction
endpackage

// File: rtl/smf_store.sv
module smf_store #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  smf_pkg::smf_ops_t ops,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);
  localparam int unsigned AW = $clog2(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr;
  logic [AW-1:0]     rd_ptr;

  // Pointers wrap naturally because DEPTH is a power of two.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      dout   <= '0;
    end else begin
      if (ops.push) wr_ptr <= wr_ptr + AW'(1);
      if (ops.pop) begin
        rd_ptr <= rd_ptr + AW'(1);
        dout   <= mem[rd_ptr];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (ops.push) mem[wr_ptr] <= din;
  end

  initial begin
    if ((1 << AW) != DEPTH) $error("smf_store: DEPTH must be a power of two");
  end
endmodule

// File: rtl/smf_level.sv
module smf_level #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned LW   = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  smf_pkg::smf_ops_t ops,
  output logic [LW-1:0]     level,
  output logic              full,
  output logic              empty
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level <= '0;
    else begin
      unique case ({ops.push, ops.pop})
        2'b10:   level <= level + LW'(1);
        2'b01:   level <= level - LW'(1);
        default: level <= level;
      endcase
    end
  end

  assign full  = (level == LW'(DEPTH));
  assign empty = (level == '0);

  // R3
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LW'(DEPTH));

  // R3
  level_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ops.push && !ops.pop) |=> (level == $past(level) + LW'(1)));
endmodule

// File: rtl/smf_thresh.sv
module smf_thresh #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned LW   = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          thr_wr,
  input  logic [LW-1:0] thr_wdata,
  input  logic [LW-1:0] level,
  output logic [LW-1:0] thr_q,
  output logic          irq
);
  logic [LW-1:0] thr_clamped;

  assign thr_clamped = (thr_wdata > LW'(DEPTH)) ? LW'(DEPTH) : thr_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      thr_q <= '0;
    else if (thr_wr) thr_q <= thr_clamped;
  end

  assign irq = (thr_q != '0) && (level >= thr_q);

  // R4
  thr_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    thr_wr |=> (thr_q <= LW'(DEPTH)));

  // R5
  irq_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> ((level < $past(level)) || $past(thr_wr)));
endmodule

// File: rtl/smf_flags.sv
module smf_flags #(
  parameter int unsigned NFLAGS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NFLAGS-1:0] set_ev,
  input  logic [NFLAGS-1:0] clr,
  output logic [NFLAGS-1:0] flags
);
  for (genvar i = 0; i < NFLAGS; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         flags[i] <= 1'b0;
      else if (set_ev[i]) flags[i] <= 1'b1;
      else if (clr[i])    flags[i] <= 1'b0;
    end

    // R6 R7: a new event always leaves its flag set
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_ev[i] |=> flags[i]);
  end
endmodule

// File: rtl/smf_top.sv
module smf_top #(
  parameter int unsigned DATA_W = smf_pkg::SMF_DATA_W,
  parameter int unsigned DEPTH  = 16,
  localparam int unsigned LW    = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cv_valid,
  input  logic [DATA_W-1:0] cv_data,
  output logic              cv_ready,
  input  logic              hr_pop,
  output logic [DATA_W-1:0] hr_data,
  output logic [LW-1:0]     level,
  input  logic              thr_wr,
  input  logic [LW-1:0]     thr_wdata,
  output logic [LW-1:0]     thr_q,
  output logic              irq,
  output logic              flag_ovf,
  output logic              flag_unf,
  input  logic              clr_ovf,
  input  logic              clr_unf
);
  import smf_pkg::*;

  smf_ops_t              ops;
  logic                  full;
  logic                  empty;
  logic [SMF_NFLAGS-1:0] set_ev;
  logic [SMF_NFLAGS-1:0] clr_ev;
  logic [SMF_NFLAGS-1:0] flags;

  assign cv_ready = !full;
  assign ops.push = cv_valid && !full;
  assign ops.pop  = hr_pop && !empty;

  assign set_ev[SMF_FLAG_OVF] = cv_valid && full;
  assign set_ev[SMF_FLAG_UNF] = hr_pop && empty;
  assign clr_ev[SMF_FLAG_OVF] = clr_ovf;
  assign clr_ev[SMF_FLAG_UNF] = clr_unf;

  assign flag_ovf = flags[SMF_FLAG_OVF];
  assign flag_unf = flags[SMF_FLAG_UNF];

  smf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .ops(ops), .din(cv_data), .dout(hr_data)
  );

  smf_level #(.DEPTH(DEPTH)) u_level (
    .clk(clk), .rst_n(rst_n), .ops(ops),
    .level(level), .full(full), .empty(empty)
  );

  smf_thresh #(.DEPTH(DEPTH)) u_thresh (
    .clk(clk), .rst_n(rst_n), .thr_wr(thr_wr), .thr_wdata(thr_wdata),
    .level(level), .thr_q(thr_q), .irq(irq)
  );

  smf_flags #(.NFLAGS(SMF_NFLAGS)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_ev(set_ev), .clr(clr_ev), .flags(flags)
  );

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cv_valid && !cv_ready) |=> (level <= $past(level)));

  // R7
  unf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hr_pop && level == '0) |=> $stable(hr_data));

  // R2
  ready_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (level == LW'(DEPTH)) |-> !cv_ready);
endmodule

// File: tb/tb_smf_top.sv
`timescale 1ns/1ps
module tb_smf_top;
  localparam int unsigned D  = 8;
  localparam int unsigned W  = 16;
  localparam int unsigned LW = $clog2(D) + 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cv_valid = 1'b0;
  logic [W-1:0]  cv_data = '0;
  logic          cv_ready;
  logic          hr_pop = 1'b0;
  logic [W-1:0]  hr_data;
  logic [LW-1:0] level;
  logic          thr_wr = 1'b0;
  logic [LW-1:0] thr_wdata = '0;
  logic [LW-1:0] thr_q;
  logic          irq;
  logic          flag_ovf, flag_unf;
  logic          clr_ovf = 1'b0, clr_unf = 1'b0;

  smf_top #(.DATA_W(W), .DEPTH(D)) dut (.*);

  always #10 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  int q[$];
  int m_thr = 0, m_data = 0;
  bit m_ovf = 0, m_unf = 0;

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // One clock: drive at the falling edge, update the model at the rising
  // edge, then compare every output a little after it.
  task automatic step(input bit v, input int d, input bit p,
                      input bit tw, input int tv, input bit co, input bit cu);
    int cnt;
    @(negedge clk);
    cv_valid = v; cv_data = W'(d); hr_pop = p;
    thr_wr = tw; thr_wdata = LW'(tv); clr_ovf = co; clr_unf = cu;
    @(posedge clk);
    cnt = q.size();
    if (p && cnt > 0) m_data = q.pop_front();
    if (v && cnt < D) q.push_back(d & 16'hFFFF);
    if (v && cnt >= D) m_ovf = 1; else if (co) m_ovf = 0;
    if (p && cnt == 0) m_unf = 1; else if (cu) m_unf = 0;
    if (tw) m_thr = (tv > D) ? D : tv;
    #1;
    check("R3", "level", int'(level), q.size());
    check("R2", "cv_ready", int'(cv_ready), int'(q.size() < D));
    check("R4", "thr_q", int'(thr_q), m_thr);
    check("R5", "irq", int'(irq), int'(m_thr != 0 && q.size() >= m_thr));
    check("R1_R8", "hr_data", int'(hr_data), m_data);
    check("R6", "flag_ovf", int'(flag_ovf), int'(m_ovf));
    check("R7", "flag_unf", int'(flag_unf), int'(m_unf));
    cv_valid = 0; hr_pop = 0; thr_wr = 0; clr_ovf = 0; clr_unf = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R9 reset state
    check("R9", "level", int'(level), 0);
    check("R9", "irq", int'(irq), 0);
    check("R9", "cv_ready", int'(cv_ready), 1);
    check("R9", "hr_data", int'(hr_data), 0);
    check("R9", "flags", int'({flag_ovf, flag_unf}), 0);
    check("R9", "thr_q", int'(thr_q), 0);
    @(negedge clk) rst_n = 1'b1;

    // Threshold sweep: fill to full, overflow once, drain, underflow once.
    for (int t = 0; t <= D + 3; t++) begin
      step(0, 0, 0, 1, t, 0, 0);
      for (int i = 0; i < D; i++) step(1, (t * 977 + i * 131) ^ 16'h5A3C, 0, 0, 0, 0, 0);
      step(1, 16'hDEAD, 0, 0, 0, 0, 0);        // R6 dropped at full
      for (int i = 0; i < D; i++) step(0, 0, 1, 0, 0, 0, 0);
      step(0, 0, 1, 0, 0, 0, 0);               // R7 pop at empty
      step(0, 0, 0, 0, 0, 1, 1);               // clear both flags
    end

    // R3 simultaneous push and pop at every fill level below full
    step(0, 0, 0, 1, 3, 0, 0);
    for (int f = 1; f < D; f++) begin
      step(1, 16'h1000 + f, 0, 0, 0, 0, 0);
      for (int k = 0; k < 3; k++) step(1, 16'h2000 + f * 8 + k, 1, 0, 0, 0, 0);
    end
    for (int i = 0; i < D; i++) step(0, 0, 1, 0, 0, 0, 0);

    // R7 push and pop at empty: pop underflows, sample still stored
    step(1, 16'hBEEF, 1, 0, 0, 0, 0);
    step(0, 0, 1, 0, 0, 0, 1);                 // pop it and clear unf
    // R7 clear meets a new underflow: flag stays set
    step(0, 0, 1, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0, 0, 1);
    // R6 clear meets a new overflow: flag stays set
    for (int i = 0; i < D; i++) step(1, 16'h7700 + i, 0, 0, 0, 0, 0);
    step(1, 16'h1111, 0, 0, 0, 1, 0);
    step(0, 0, 0, 0, 0, 1, 0);
    // R5 threshold rewrite while full releases and re-raises irq
    step(0, 0, 0, 1, 0, 0, 0);
    step(0, 0, 0, 1, D, 0, 0);
    // R2 full plus pop: offered beat still dropped, pop proceeds
    step(1, 16'h2222, 1, 0, 0, 0, 0);
    for (int i = 0; i < D; i++) step(0, 0, 1, 0, 0, 0, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule